// File: doc/BRIEF.md
# Runtime-Modulus Modular Multiply-Add

This block computes (X·Y + W) mod M by a radix-2 left-to-right recurrence. The modulus M is an ordinary input, so the block is not tied to one modulus at design time. A pulse on `start` captures M and Y. The two multiplier-side operands X and W then arrive one bit per cycle, most significant bit first, over R cycles. Each cycle the accumulator is doubled and the current bits are added in. The part of the sum at bit n−1 and above is folded back through a small residue table that holds (2^(n−1)·k) mod M.

The residue table is not precomputed. Two of its entries are seeded as constants. One subtract-then-conditionally-add lane pair derives two further entries per cycle, using the recursion step a = 2M − 2^n. The first pair is derived in a single preparation cycle, and the remaining pairs are derived while the iterations are already running. A table entry that is being derived in the same cycle it is needed is forwarded straight from the lane output.

Before the last reduction, the accumulator is either the residue or the residue plus M. It can therefore feed back into a following operation, for example a squaring step, with no correction in between. A final correction cycle optionally subtracts M once to give the canonical residue. The block drives `done` for one cycle and holds `result` until the next operation finishes.

Top module: `modmul_add_rt`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done` is 0 and `result` is 0.
- R2: With CANON=1, a modulus M with 2^(N−1) < M < 2^N, 0 ≤ Y < M, and R-bit X and W supplied on `x_bit`/`w_bit` most significant bit first (bit R−1 in the first iteration cycle), `result` equals (X·Y + W) mod M.
- R3: Y may be any (N+1)-bit value below (2^(N+2) + 11 − 4·(N mod 2))/3, including values above M, and `result` is still (X·Y + W) mod M.
- R4: For every admissible M, each table entry k in 2..7 equals (2^(N−1)·k) mod M. Entry k is derived from entry k−2 by subtracting a = 2M − 2^N and adding M back when the difference is negative. Entries 0 and 1 are the constants 0 and 2^(N−1), and every derived entry is below M.
- R5: An iteration never selects a table entry that is neither already stored nor being derived in that same cycle. Entries 2,3 are derived in the preparation cycle, and entries 4,5 and 6,7 in the first and second iteration cycles.
- R6: The intermediate sum 2·P + x·Y + w always fits in N+2 bits. Its top three bits form the table index. Before the final correction, the accumulator is below 2M.
- R7: `done` is high for exactly one cycle, R+2 clock edges after the edge that samples `start` (one preparation cycle, R iteration cycles, one correction cycle). `result` changes only in the cycle where `done` is high.
- R8: A `start` pulse while an operation is in progress has no effect on that operation's result or timing.
- R9: M and Y are captured when `start` is accepted. Changes on `mod_in` and `y_in` during an operation have no effect on its result.
- R10: A result fed back as both X and Y of the next operation (modular squaring) gives the correct residue with no intermediate correction step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| mod_in | input | N | Modulus M, sampled with start |
| y_in | input | N+1 | Operand Y, sampled with start |
| x_bit | input | 1 | Current bit of X, most significant first, one per iteration cycle |
| w_bit | input | 1 | Current bit of W, most significant first, one per iteration cycle |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | N+1 | Final residue (canonical when CANON=1), held between operations |

## Verification
The hardest situation to reach from the ports is the second iteration selecting table entry 6. That entry is still being derived in that cycle, so it must come from the forwarding path rather than from storage. Reaching it needs an accumulator near 2^N after the first step, together with a Y close to its upper bound. The stimulus therefore drives all-ones X and W with Y at the largest allowed value, sweeps M across its whole range (including the modulus at which the intermediate sum peaks), and checks every result against an arithmetic model.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2,
    ST_FIX  = 2'd3
  } mm_state_e;
endpackage

// File: rtl/modmul_lane.sv
// One derivation lane: entry(k) from entry(k-2), reduced by a = 2M - 2^N.
module modmul_lane #(
  parameter int N = 8
) (
  input  logic [N-1:0] prev,
  input  logic [N-1:0] m,
  input  logic [N-1:0] a,
  output logic [N-1:0] next
);
  function automatic logic [N-1:0] step_down(input logic [N-1:0] p,
                                             input logic [N-1:0] mm,
                                             input logic [N-1:0] aa);
    logic [N:0] diff;
    diff = {1'b0, p} - {1'b0, aa};
    // sign of the subtracter picks the adder output (difference plus M)
    return diff[N] ? (diff[N-1:0] + mm) : diff[N-1:0];
  endfunction

  assign next = step_down(prev, m, a);
endmodule

// File: rtl/modmul_table.sv
// Residue table of (2^(N-1)*k) mod M, k = 0..7, filled two entries per cycle.
module modmul_table #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv_en,
  input  logic [N-1:0] m,
  input  logic [2:0]   idx,
  output logic [N-1:0] entry,
  output logic         lookup_ok,
  output logic         gen_we,
  output logic [N-1:0] gen_lo,
  output logic [N-1:0] gen_hi
);
  localparam int NE = 8;
  localparam int LANES = 2;
  localparam logic [1:0] STAGE_FULL = 2'd3;

  logic [1:0]   stage_q;
  logic [N-1:0] tab   [NE];
  logic [NE-1:0] avail;
  logic [N-1:0] gen   [LANES];
  logic [N-1:0] a_val;
  logic         fwd_hit;

  // 2M - 2^N, valid because 2^(N-1) < M < 2^N
  assign a_val  = {m[N-2:0], 1'b0};
  assign gen_we = adv_en && (stage_q != STAGE_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stage_q <= '0;
    else if (load)   stage_q <= '0;
    else if (gen_we) stage_q <= stage_q + 2'd1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    modmul_lane #(.N(N)) u_lane (
      .prev (tab[{stage_q, 1'(l)}]),
      .m    (m),
      .a    (a_val),
      .next (gen[l])
    );
  end

  for (genvar k = 0; k < NE; k++) begin : g_ent
    if (k == 0) begin : g_zero
      assign tab[k]   = '0;
      assign avail[k] = 1'b1;
    end else if (k == 1) begin : g_half
      assign tab[k]   = N'(1) << (N - 1);
      assign avail[k] = 1'b1;
    end else begin : g_reg
      logic [N-1:0] val_q;
      logic         vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
          vld_q <= 1'b0;
        end else if (load) begin
          vld_q <= 1'b0;
        end else if (gen_we && (stage_q == 2'(k / 2 - 1))) begin
          val_q <= gen[k % 2];
          vld_q <= 1'b1;
        end
      end
      assign tab[k]   = val_q;
      assign avail[k] = vld_q;
    end
  end

  // entries derived this very cycle are forwarded from the lanes
  assign fwd_hit   = gen_we && (idx[2:1] == 2'(stage_q + 2'd1));
  assign entry     = avail[idx] ? tab[idx] : (fwd_hit ? gen[idx[0]] : '0);
  assign lookup_ok = avail[idx] || fwd_hit;
  assign gen_lo    = gen[0];
  assign gen_hi    = gen[1];
endmodule

// File: rtl/modmul_step.sv
// One radix-2 iteration: T = 2P + x*Y + w, P' = T mod 2^(N-1) + table(T div 2^(N-1)).
module modmul_step #(
  parameter int N = 8
) (
  input  logic [N:0]   p,
  input  logic [N:0]   y,
  input  logic         xb,
  input  logic         wb,
  input  logic [N-1:0] entry,
  output logic [2:0]   idx,
  output logic [N:0]   p_next,
  output logic         ovf
);
  localparam int TW = N + 3;

  function automatic logic [TW-1:0] form_sum(input logic [N:0] pp,
                                             input logic [N:0] yy,
                                             input logic x, input logic w);
    logic [TW-1:0] s;
    s = {1'b0, pp, 1'b0};
    if (x) s = s + {2'b00, yy};
    s = s + TW'(w);
    return s;
  endfunction

  logic [TW-1:0] t_full;

  assign t_full = form_sum(p, y, xb, wb);
  assign ovf    = t_full[TW-1];
  assign idx    = t_full[N+1:N-1];
  assign p_next = {2'b00, t_full[N-2:0]} + {1'b0, entry};
endmodule

// File: rtl/modmul_add_rt.sv
module modmul_add_rt
  import modmul_pkg::*;
#(
  parameter int N     = 8,
  parameter int R     = 8,
  parameter bit CANON = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] mod_in,
  input  logic [N:0]   y_in,
  input  logic         x_bit,
  input  logic         w_bit,
  output logic         done,
  output logic [N:0]   result
);
  localparam int CW = (R > 1) ? $clog2(R) : 1;
  localparam logic [CW-1:0] LAST = CW'(R - 1);

  mm_state_e    state_q;
  logic [N-1:0] m_q;
  logic [N:0]   y_q;
  logic [N:0]   p_q;
  logic [CW-1:0] cnt_q;
  logic [N:0]   res_q;
  logic         done_q;

  logic         in_idle, in_prep, in_iter, in_fix, load;
  logic [2:0]   tidx;
  logic [N-1:0] tentry;
  logic         lookup_ok, gen_we, ovf;
  logic [N-1:0] gen_lo, gen_hi;
  logic [N:0]   p_next, p_fixed;

  function automatic logic [N:0] final_fix(input logic [N:0] pv, input logic [N-1:0] mv);
    if (CANON && (pv >= {1'b0, mv})) return pv - {1'b0, mv};
    return pv;
  endfunction

  assign in_idle = (state_q == ST_IDLE);
  assign in_prep = (state_q == ST_PREP);
  assign in_iter = (state_q == ST_ITER);
  assign in_fix  = (state_q == ST_FIX);
  assign load    = in_idle && start;
  assign p_fixed = final_fix(p_q, m_q);

  modmul_table #(.N(N)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .adv_en    (in_prep || in_iter),
    .m         (m_q),
    .idx       (tidx),
    .entry     (tentry),
    .lookup_ok (lookup_ok),
    .gen_we    (gen_we),
    .gen_lo    (gen_lo),
    .gen_hi    (gen_hi)
  );

  modmul_step #(.N(N)) u_step (
    .p      (p_q),
    .y      (y_q),
    .xb     (x_bit),
    .wb     (w_bit),
    .entry  (tentry),
    .idx    (tidx),
    .p_next (p_next),
    .ovf    (ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      m_q     <= '0;
      y_q     <= '0;
      p_q     <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          m_q     <= mod_in;
          y_q     <= y_in;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          p_q     <= '0;
          cnt_q   <= '0;
          state_q <= ST_ITER;
        end
        ST_ITER: begin
          p_q   <= p_next;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          res_q   <= p_fixed;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/modmul_add_rt_chk.sv
module modmul_add_rt_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_idle,
  input logic         in_iter,
  input logic         in_fix,
  input logic         lookup_ok,
  input logic         gen_we,
  input logic [N-1:0] gen_lo,
  input logic [N-1:0] gen_hi,
  input logic [N-1:0] m_q,
  input logic         ovf,
  input logic [N:0]   p_q,
  input logic         done,
  input logic [N:0]   result
);
  assert_entry_below_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_we |-> ((gen_lo < m_q) && (gen_hi < m_q)));

  assert_lookup_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_iter |-> lookup_ok);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_iter |-> !ovf);

  assert_raw_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_fix |-> (p_q < {m_q, 1'b0}));

  assert_done_after_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fix |=> done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_mod_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && !$past(in_idle)) |-> $stable(m_q));
endmodule

bind modmul_add_rt modmul_add_rt_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_idle   (in_idle),
  .in_iter   (in_iter),
  .in_fix    (in_fix),
  .lookup_ok (lookup_ok),
  .gen_we    (gen_we),
  .gen_lo    (gen_lo),
  .gen_hi    (gen_hi),
  .m_q       (m_q),
  .ovf       (ovf),
  .p_q       (p_q),
  .done      (done),
  .result    (result)
);

// File: tb/modmul_add_rt_bench.sv
module modmul_add_rt_bench;
  localparam int N = 8;
  localparam int R = 8;
  localparam int YBOUND = ((1 << (N + 2)) + 11 - 4 * (N % 2)) / 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] mod_in = '0;
  logic [N:0]   y_in = '0;
  logic         x_bit = 1'b0;
  logic         w_bit = 1'b0;
  logic         done;
  logic [N:0]   result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  modmul_add_rt #(.N(N), .R(R), .CANON(1'b1)) u_modmul_add_rt (
    .clk(clk), .rst_n(rst_n), .start(start), .mod_in(mod_in), .y_in(y_in),
    .x_bit(x_bit), .w_bit(w_bit), .done(done), .result(result)
  );

  function automatic longint ref_mma(longint x, longint y, longint w, longint m);
    return (x * y + w) % m;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full operation; disturb toggles start and scrambles M/Y while busy
  task automatic run_op(input logic [R-1:0] xv, input logic [R-1:0] wv,
                        input logic [N:0] yv, input logic [N-1:0] mv,
                        input bit disturb, output logic [N:0] res);
    @(negedge clk);
    start = 1'b1; mod_in = mv; y_in = yv; x_bit = 1'b0; w_bit = 1'b0;
    @(posedge clk);                       // start sampled
    @(negedge clk);
    start = disturb; chk(done == 1'b0, "R7", done, 0);
    if (disturb) begin mod_in = ~mv; y_in = ~yv; end
    @(posedge clk);                       // preparation edge
    for (int j = R - 1; j >= 0; j--) begin
      @(negedge clk);
      x_bit = xv[j]; w_bit = wv[j];
      if (disturb) begin start = j[0]; mod_in = mv ^ N'(j); end
      chk(done == 1'b0, "R7", done, 0);
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0; mod_in = mv; y_in = yv;
    chk(done == 1'b0, "R7", done, 0);
    @(posedge clk);                       // correction edge: R+2 after start
    @(negedge clk);
    chk(done == 1'b1, "R7", done, 1);
    res = result;
    @(negedge clk);
    chk(done == 1'b0, "R7", done, 0);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1", done, 0);
    chk(result == '0, "R1", result, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1", done, 0);
    chk(result == '0, "R1", result, 0);
  endtask

  task automatic t_basic();
    logic [N:0] r;
    run_op(8'd0, 8'd0, 9'd0, 8'd129, 1'b0, r);
    chk(r == ref_mma(0, 0, 0, 129), "R2", r, ref_mma(0, 0, 0, 129));
    run_op(8'd255, 8'd255, 9'd254, 8'd255, 1'b0, r);
    chk(r == ref_mma(255, 254, 255, 255), "R2", r, ref_mma(255, 254, 255, 255));
    run_op(8'd200, 8'd7, 9'd100, 8'd200, 1'b0, r);
    chk(r == ref_mma(200, 100, 7, 200), "R2", r, ref_mma(200, 100, 7, 200));
    run_op(8'd1, 8'd0, 9'd128, 8'd129, 1'b0, r);
    chk(r == ref_mma(1, 128, 0, 129), "R2", r, ref_mma(1, 128, 0, 129));
    run_op(8'b1010_0101, 8'b0101_1010, 9'd77, 8'd181, 1'b0, r);
    chk(r == ref_mma(165, 77, 90, 181), "R2", r, ref_mma(165, 77, 90, 181));
  endtask

  // Y at its bound: stresses the sum width (R6) and the forwarded entry (R5)
  task automatic t_large_y();
    logic [N:0] r;
    logic [N:0] yb;
    yb = 9'(YBOUND - 1);
    run_op(8'd255, 8'd255, yb, 8'd214, 1'b0, r);
    chk(r == ref_mma(255, YBOUND - 1, 255, 214), "R3 R6", r, ref_mma(255, YBOUND - 1, 255, 214));
    run_op(8'd255, 8'd255, yb, 8'd129, 1'b0, r);
    chk(r == ref_mma(255, YBOUND - 1, 255, 129), "R3 R5", r, ref_mma(255, YBOUND - 1, 255, 129));
    run_op(8'b1100_0011, 8'd1, 9'd300, 8'd255, 1'b0, r);
    chk(r == ref_mma(195, 300, 1, 255), "R3", r, ref_mma(195, 300, 1, 255));
  endtask

  // modulus sweep: every table entry is exercised across the admissible range
  task automatic t_table();
    logic [N:0] r;
    for (int mv = 129; mv <= 255; mv += 18) begin
      run_op(8'd255, 8'd255, 9'(mv - 1), 8'(mv), 1'b0, r);
      chk(r == ref_mma(255, mv - 1, 255, mv), "R4", r, ref_mma(255, mv - 1, 255, mv));
      run_op(8'd255, 8'd170, 9'(YBOUND - 1), 8'(mv), 1'b0, r);
      chk(r == ref_mma(255, YBOUND - 1, 170, mv), "R4 R5", r, ref_mma(255, YBOUND - 1, 170, mv));
    end
  endtask

  task automatic t_hold();
    logic [N:0] r;
    run_op(8'd99, 8'd3, 9'd150, 8'd211, 1'b0, r);
    chk(r == ref_mma(99, 150, 3, 211), "R7", r, ref_mma(99, 150, 3, 211));
    repeat (4) @(negedge clk);
    chk(result == r, "R7", result, r);
    chk(done == 1'b0, "R7", done, 0);
  endtask

  task automatic t_busy();
    logic [N:0] r;
    run_op(8'd123, 8'd45, 9'd190, 8'd233, 1'b1, r);
    chk(r == ref_mma(123, 190, 45, 233), "R8 R9", r, ref_mma(123, 190, 45, 233));
    run_op(8'd255, 8'd255, 9'(YBOUND - 1), 8'd150, 1'b1, r);
    chk(r == ref_mma(255, YBOUND - 1, 255, 150), "R9", r, ref_mma(255, YBOUND - 1, 255, 150));
  endtask

  task automatic t_chain();
    logic [N:0] r1, r2, r3;
    longint e1, e2, e3;
    e1 = ref_mma(173, 201, 0, 251);
    run_op(8'd173, 8'd0, 9'd201, 8'd251, 1'b0, r1);
    chk(r1 == e1, "R10", r1, e1);
    e2 = ref_mma(e1, e1, 0, 251);
    run_op(r1[R-1:0], 8'd0, r1, 8'd251, 1'b0, r2);
    chk(r2 == e2, "R10", r2, e2);
    e3 = ref_mma(e2, e2, 17, 251);
    run_op(r2[R-1:0], 8'd17, r2, 8'd251, 1'b0, r3);
    chk(r3 == e3, "R10", r3, e3);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_large_y();
    t_table();
    t_hold();
    t_busy();
    t_chain();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule